// File: doc/BRIEF.md
# Vector AES Single-Round Encryption Datapath

This block applies one reduced AES encryption round to every 128-bit segment of a wide vector. Each segment of the state operand is first combined with the matching segment of the round-key operand by XOR. The bytes are then rotated by row, and finally every byte passes through the forward AES substitution box. No column mixing is applied, so the substituted bytes are the final result.

The vector width `VL` is a parameter. It must be a multiple of 128 from 128 up to 2048, and elaboration stops for any other value. All segments are processed at once with replicated logic. No segment can be masked or skipped. The result has the same width and segment layout as the state operand, so it can be written straight back in place of the state. With `REGISTERED` set to 1 (the default), one register stage adds a single cycle of latency. Setting it to 0 gives a purely combinational path.

Top module: `vecAesRound`

## Requirements
- R1: For each segment, the result equals SubBytes(ShiftRows(state XOR key)). The XOR comes first, so a segment whose key equals its state yields sixteen 0x63 bytes.
- R2: Inside a segment, byte i occupies bits [8i+7:8i] and stands at row i mod 4, column i div 4 (column-major).
- R3: The rotation places input byte (row r, column (c+r) mod 4) at output position (r, c). Row 0 is unchanged and row r moves left by r bytes.
- R4: Substitution uses the forward AES S-box: the multiplicative inverse in GF(2^8) modulo 0x11B (zero maps to zero), followed by the affine map with constant 0x63. All-zero state and key give 0x63 in every output byte.
- R5: Segment s of the result depends only on segment s of both operands. Every segment is updated on every accepted input.
- R6: With REGISTERED=1, `resVld` equals the value of `opVld` at the previous rising clock edge, and every accepted input produces exactly one result.
- R7: A synchronous active-low reset (`rstN` low at a rising edge) clears `resVld` at that edge, even while `opVld` is high.
- R8: While `opVld` is low, the operand inputs are ignored and `resData` holds the last computed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| opVld | input | 1 | Operands valid this cycle |
| opState | input | VL | State vector, VL/128 segments |
| opKey | input | VL | Round-key vector, same layout as opState |
| resVld | output | 1 | Result valid |
| resData | output | VL | Transformed state vector |

## Verification
The assertions assume that the operands carry known values whenever `opVld` is high, and that the operands are driven with defined data while reset is held. Without that, the hold check on the result register would compare unknown values. The bench keeps to this. It holds reset for several cycles with `opVld` high and known operands. It changes inputs only a little after each rising edge. During idle cycles it fills the operand buses with fresh random data, so any leak into the result register shows up at the output.

// File: rtl/vecAesRound_pkg.sv
package vecAesRound_pkg;

  localparam int SEG_BITS  = 128;
  localparam int SEG_BYTES = SEG_BITS / 8;
  localparam int ROWS      = 4;
  localparam int VL_MAX    = 2048;
  localparam logic [7:0] GF_POLY_LOW = 8'h1b;
  localparam logic [7:0] AFFINE_C    = 8'h63;
  localparam int INV_EXP   = 254;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
  } aesStrobes_t;

  // Multiply in GF(2^8) modulo x^8+x^4+x^3+x+1.
  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? GF_POLY_LOW : 8'h00);
    end
    return acc;
  endfunction

  // Inverse as x^254 (square-and-multiply); zero maps to zero.
  function automatic logic [7:0] gfInv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = x;
    for (int k = 0; k < 8; k++) begin
      if (((INV_EXP >> k) & 1) == 1) r = gfMul(r, p);
      p = gfMul(p, p);
    end
    return r;
  endfunction

  // Forward substitution: inverse then affine transform.
  function automatic logic [7:0] sboxFwd(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] o;
    inv = gfInv(x);
    for (int i = 0; i < 8; i++) begin
      o[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^
             inv[(i + 6) % 8] ^ inv[(i + 7) % 8] ^ AFFINE_C[i];
    end
    return o;
  endfunction

  // Source byte index feeding output byte idx after row rotation.
  function automatic int rowShiftSource(input int idx);
    int r;
    int c;
    r = idx % ROWS;
    c = idx / ROWS;
    return r + ROWS * ((c + r) % ROWS);
  endfunction

endpackage

// File: rtl/aesSegment.sv
module aesSegment
  import vecAesRound_pkg::*;
(
  input  logic [SEG_BITS-1:0] segState,
  input  logic [SEG_BITS-1:0] segKey,
  output logic [SEG_BITS-1:0] segOut
);

  logic [SEG_BITS-1:0] keyed;

  // Key addition happens before rotation and substitution.
  assign keyed = segState ^ segKey;

  for (genvar b = 0; b < SEG_BYTES; b++) begin : g_byte
    localparam int SRC = rowShiftSource(b);
    assign segOut[8*b +: 8] = sboxFwd(keyed[8*SRC +: 8]);
  end

endmodule

// File: rtl/aesRoundDatapath.sv
module aesRoundDatapath
  import vecAesRound_pkg::*;
#(
  parameter int VL         = 256,
  parameter bit REGISTERED = 1'b1
) (
  input  logic          clk,
  input  aesStrobes_t   strobes,
  input  logic [VL-1:0] dpState,
  input  logic [VL-1:0] dpKey,
  output logic [VL-1:0] dpResult
);

  localparam int SEGS = VL / SEG_BITS;

  logic [VL-1:0] roundComb;

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    aesSegment u_seg (
      .segState (dpState[s*SEG_BITS +: SEG_BITS]),
      .segKey   (dpKey[s*SEG_BITS +: SEG_BITS]),
      .segOut   (roundComb[s*SEG_BITS +: SEG_BITS])
    );
  end

  if (REGISTERED) begin : g_reg
    logic [VL-1:0] resultQ;
    // Data register has no reset; it loads only on accepted operands.
    always_ff @(posedge clk) begin
      if (strobes.load) resultQ <= roundComb;
    end
    assign dpResult = resultQ;
  end else begin : g_comb
    assign dpResult = roundComb;
  end

endmodule

// File: rtl/aesRoundCtrl.sv
module aesRoundCtrl
  import vecAesRound_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opVld,
  output aesStrobes_t strobes,
  output logic        resVld
);

  always_comb begin
    strobes      = '0;
    strobes.load = opVld;
  end

  if (REGISTERED) begin : g_reg
    logic vldQ;
    always_ff @(posedge clk) begin
      if (!rstN) vldQ <= 1'b0;
      else       vldQ <= opVld;
    end
    assign resVld = vldQ;
  end else begin : g_comb
    assign resVld = opVld;
  end

endmodule

// File: rtl/vecAesRound.sv
module vecAesRound
  import vecAesRound_pkg::*;
#(
  parameter int VL         = 256,
  parameter bit REGISTERED = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opVld,
  input  logic [VL-1:0] opState,
  input  logic [VL-1:0] opKey,
  output logic          resVld,
  output logic [VL-1:0] resData
);

  if ((VL % SEG_BITS) != 0 || VL < SEG_BITS || VL > VL_MAX) begin : g_badVl
    $error("vecAesRound: VL must be a multiple of 128 in 128..2048");
  end

  aesStrobes_t strobes;

  aesRoundCtrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opVld   (opVld),
    .strobes (strobes),
    .resVld  (resVld)
  );

  aesRoundDatapath #(.VL(VL), .REGISTERED(REGISTERED)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .dpState  (opState),
    .dpKey    (opKey),
    .dpResult (resData)
  );

endmodule

// File: rtl/vecAesRound_checker.sv
module vecAesRound_checker #(
  parameter int VL         = 256,
  parameter bit REGISTERED = 1'b1
) (
  input logic          clk,
  input logic          rstN,
  input logic          opVld,
  input logic [VL-1:0] opState,
  input logic [VL-1:0] opKey,
  input logic          resVld,
  input logic [VL-1:0] resData
);

  localparam int SEGS = VL / 128;

  if (REGISTERED) begin : g_chk
    // R6: an accepted input yields a valid result one edge later
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
      opVld |=> resVld);
    // R6: no input, no result
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
      !opVld |=> !resVld);
    // R7: synchronous reset clears the valid flag
    assert_reset_clears_R7: assert property (@(posedge clk)
      !rstN |=> !resVld);
    // R8: idle cycles leave the result untouched
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
      !opVld |=> $stable(resData));
    // R4: all-zero operands give 0x63 everywhere
    assert_zero_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
      (opVld && opState == '0 && opKey == '0) |=> resData == {(VL/8){8'h63}});

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
      // R1, R5: a segment whose key cancels its state gives 0x63 bytes there
      assert_seg_cancel_R5: assert property (@(posedge clk) disable iff (!rstN)
        (opVld && opState[s*128 +: 128] == opKey[s*128 +: 128])
        |=> resData[s*128 +: 128] == {16{8'h63}});
    end
  end

endmodule

bind vecAesRound vecAesRound_checker #(.VL(VL), .REGISTERED(REGISTERED)) u_check (
  .clk     (clk),
  .rstN    (rstN),
  .opVld   (opVld),
  .opState (opState),
  .opKey   (opKey),
  .resVld  (resVld),
  .resData (resData)
);

// File: tb/vecAesRound_tb.sv
`timescale 1ns/1ps
module vecAesRound_tb;

  localparam int VL   = 256;
  localparam int SEGS = VL / 128;

  logic          clk = 1'b0;
  logic          rstN;
  logic          opVld;
  logic [VL-1:0] opState;
  logic [VL-1:0] opKey;
  logic          resVld;
  logic [VL-1:0] resData;

  always #5 clk = ~clk;

  vecAesRound #(.VL(VL), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .opVld(opVld), .opState(opState),
    .opKey(opKey), .resVld(resVld), .resData(resData)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] expT [256];
  int         logT [256];
  logic [7:0] sboxT[256];

  logic [VL-1:0] expQ[$];
  string         tagQ[$];
  logic [VL-1:0] heldVal;
  bit            holdValid = 0;
  logic          sentVld   = 1'b0;
  logic          sentRst   = 1'b0;

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  // Independent S-box: exp/log tables over generator 3, then affine map.
  initial begin
    logic [7:0] x;
    x = 8'h01;
    for (int i = 0; i < 255; i++) begin
      expT[i] = x;
      logT[x] = i;
      x = x ^ ({x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00));
    end
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv;
      inv = (v == 0) ? 8'h00 : expT[(255 - logT[v]) % 255];
      sboxT[v] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    end
  end

  function automatic logic [VL-1:0] model(input logic [VL-1:0] st, input logic [VL-1:0] ky);
    logic [VL-1:0] t;
    logic [VL-1:0] o;
    t = st ^ ky;
    o = '0;
    for (int s = 0; s < SEGS; s++) begin
      for (int i = 0; i < 16; i++) begin
        int r;
        int c;
        int src;
        r   = i % 4;
        c   = i / 4;
        src = r + 4 * ((c + r) % 4);
        o[s*128 + i*8 +: 8] = sboxT[t[s*128 + src*8 +: 8]];
      end
    end
    return o;
  endfunction

  function automatic logic [VL-1:0] randVec();
    logic [VL-1:0] v;
    for (int w = 0; w < VL / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic checkBit(input bit ok, input string req, input logic act, input logic expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic checkVec(input string req, input logic [VL-1:0] act, input logic [VL-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [VL-1:0] st, input logic [VL-1:0] ky, input string tag);
    @(posedge clk); #2;
    opVld   = 1'b1;
    opState = st;
    opKey   = ky;
    expQ.push_back(model(st, ky));
    tagQ.push_back(tag);
  endtask

  // R8 stimulus: operands toggle while not valid.
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      opVld   = 1'b0;
      opState = randVec();
      opKey   = randVec();
    end
  endtask

  always @(posedge clk) begin
    sentVld <= opVld;
    sentRst <= rstN;
  end

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (sentRst) checkBit(resVld === sentVld, "R6 valid latency", resVld, sentVld);
    if (rstN && resVld) begin
      if (expQ.size() == 0) begin
        checkBit(1'b0, "R6 unexpected result", resVld, 1'b0);
      end else begin
        logic [VL-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVec(t, resData, e);
        heldVal   = e;
        holdValid = 1;
      end
    end else if (rstN && holdValid) begin
      checkVec("R8 hold while idle", resData, heldVal);
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    logic [VL-1:0] v;
    logic [VL-1:0] k;
    // R7: reset dominates a high valid input.
    rstN    = 1'b0;
    opVld   = 1'b1;
    opState = randVec();
    opKey   = randVec();
    repeat (3) @(posedge clk);
    #2;
    checkBit(resVld === 1'b0, "R7 reset state", resVld, 1'b0);
    rstN  = 1'b1;
    opVld = 1'b0;
    idle(2);

    // R4: zero operands.
    send('0, '0, "R4 zero vector");
    idle(2);

    // R2, R3: byte counter pattern with zero key.
    for (int s = 0; s < SEGS; s++)
      for (int i = 0; i < 16; i++) v[s*128 + i*8 +: 8] = 8'(i);
    send(v, '0, "R2 R3 byte order and rotation");
    idle(1);

    // R1: key equal to state cancels.
    v = randVec();
    send(v, v, "R1 key added first");

    // R5: segment 0 cancels, others random.
    v = randVec();
    k = randVec();
    k[127:0] = v[127:0];
    send(v, k, "R5 segment independence");
    idle(3);

    // Back-to-back and gapped random traffic.
    for (int n = 0; n < 40; n++) begin
      send(randVec(), randVec(), "R1 random round");
      if (n % 5 == 4) idle(2);
    end
    idle(3);

    // R7: reset in mid-run with valid high.
    @(posedge clk); #2;
    rstN    = 1'b0;
    opVld   = 1'b1;
    opState = randVec();
    @(posedge clk); #2;
    checkBit(resVld === 1'b0, "R7 mid-run reset", resVld, 1'b0);
    holdValid = 0;
    rstN  = 1'b1;
    opVld = 1'b0;
    idle(2);

    send(randVec(), '0, "R4 random state zero key");
    idle(4);
    checkBit(expQ.size() == 0, "R6 all inputs produced results", expQ.size() == 0, 1'b1);

    done = 1;
    finishRun();
  end

endmodule